// File: doc/BRIEF.md
# Reloading Timer with Overflow Masking

This block is a general-purpose timer built around a free-running up-counter. The counter advances once per clock while the timer runs. When it reaches all ones it rolls over and either reloads from a programmable start value or drops to zero. A compare register marks a point inside each period. Together the reload and the compare shape a PWM waveform: the output rises when the counter reloads and falls when it matches the compare value. Software sets the period P by writing the start value as all-ones minus (P - 1).

Overflow interrupts can be thinned out. A 16-bit wrap count N lets only every Nth rollover set the overflow flag, which lowers the interrupt rate on short periods. Writes to the control, counter and start-value registers are posted. Each one takes effect a fixed two cycles after the bus write, and a status register shows which of those writes are still in flight.

The register port is a simple synchronous bus with a valid strobe, a write flag and a byte address. It is always ready, and read data is returned combinationally in the same cycle.

Top module: `wrap_timer`

## Requirements
- R1: After reset every register reads zero, the counter is stopped, and irq_cmp, irq_ovf and pwm_out are low.
- R2: While running (control bit 0 = 1), the counter at offset 0x3C increases by exactly one per clock when it is below all ones.
- R3: At all ones, the next clock loads the counter from the start-value register at 0x40 if auto-reload (control bit 1) is set, and loads zero otherwise.
- R4: Writes to control (0x38), counter (0x3C) and start value (0x40) are posted. The pending-status register at 0x48 shows bit 0 for control, bit 1 for counter and bit 2 for start value. The bit reads 1 for exactly two cycles after the write cycle. The written value takes effect on the edge that clears the bit and is not visible before it.
- R5: When compare is enabled (control bit 6) and the timer runs, the counter equalling the compare register at 0x4C sets the compare flag, which is bit 0 of the interrupt status at 0x28.
- R6: The wrap register at 0x6C holds N, the number of rollovers per overflow flag. The flag (status bit 1) is set on every Nth rollover, and N = 0 acts as 1. Writing the wrap register restarts the rollover count from zero.
- R7: Status flags are cleared by writing 1 to their bit. A new event in the same cycle wins over the clear. irq_cmp is status bit 0 AND enable bit 0 at 0x2C, and irq_ovf is status bit 1 AND enable bit 1.
- R8: pwm_out goes high on the clock where the counter reloads, goes low on the clock after a compare match, and is low while the timer is stopped. A period of P ticks with the compare value placed H - 1 ticks after the start value gives H high cycles per period.
- R9: While stopped, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Request accepted (always 1) |
| bus_rdata | output | 32 | Read data, combinational |
| irq_cmp | output | 1 | Compare interrupt |
| irq_ovf | output | 1 | Masked overflow interrupt |
| pwm_out | output | 1 | PWM waveform |

## Verification
The assertions assume that a bus write is a single-cycle valid pulse, and that nothing writes the counter in the same cycle as a rollover or compare they reason about. Under that assumption an applied counter write takes priority, and the properties exclude that cycle. The stimulus issues one write at a time. It waits three cycles after every posted write before depending on its effect, and it picks random periods of 3 to 10 ticks and wrap counts of 0 to 4. This keeps every interval long enough for a status clear to land before the next event.

// File: rtl/wtmr_pkg.sv
package wtmr_pkg;
  localparam logic [7:0] OFS_ISTAT = 8'h28;
  localparam logic [7:0] OFS_IEN   = 8'h2C;
  localparam logic [7:0] OFS_CTRL  = 8'h38;
  localparam logic [7:0] OFS_CNT   = 8'h3C;
  localparam logic [7:0] OFS_LOAD  = 8'h40;
  localparam logic [7:0] OFS_POST  = 8'h48;
  localparam logic [7:0] OFS_CMP   = 8'h4C;
  localparam logic [7:0] OFS_WRAP  = 8'h6C;

  localparam int unsigned CTRL_RUN_B = 0;
  localparam int unsigned CTRL_ARL_B = 1;
  localparam int unsigned CTRL_CMP_B = 6;

  localparam int unsigned NSLOT     = 3;
  localparam int unsigned SLOT_CTRL = 0;
  localparam int unsigned SLOT_CNT  = 1;
  localparam int unsigned SLOT_LOAD = 2;

  typedef struct packed {
    logic cmp_en;
    logic arl;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/wtmr_post_slot.sv
module wtmr_post_slot #(
  parameter int unsigned DW  = 32,
  parameter int unsigned LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          pend_o,
  output logic          apply_o,
  output logic [DW-1:0] data_o
);
  localparam int unsigned AW = (LAT > 1) ? $clog2(LAT) : 1;

  logic          pend_q, pend_d;
  logic [AW-1:0] age_q, age_d;
  logic [DW-1:0] data_q, data_d;
  logic          apply;

  assign apply = pend_q && (age_q == AW'(LAT - 1));

  always_comb begin
    pend_d = pend_q;
    age_d  = age_q;
    data_d = data_q;
    if (wr_i) begin
      pend_d = 1'b1;
      age_d  = '0;
      data_d = wdata_i;
    end else if (apply) begin
      pend_d = 1'b0;
    end else if (pend_q) begin
      age_d = age_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      age_q  <= '0;
    end else begin
      pend_q <= pend_d;
      age_q  <= age_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else if (wr_i) data_q <= data_d;
  end

  assign pend_o  = pend_q;
  assign apply_o = apply;
  assign data_o  = data_q;
endmodule

// File: rtl/wtmr_core.sv
module wtmr_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             arl_i,
  input  logic             cmp_en_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             cnt_set_i,
  input  logic [CNT_W-1:0] cnt_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_evt_o,
  output logic             cmp_evt_o,
  output logic             pwm_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             pwm_q, pwm_d;
  logic             ovf_evt, cmp_evt;

  assign ovf_evt = run_i && (cnt_q == CNT_MAX) && !cnt_set_i;
  assign cmp_evt = run_i && cmp_en_i && (cnt_q == cmp_i) && !cnt_set_i;
  assign cnt_en  = cnt_set_i || run_i;

  always_comb begin
    if (cnt_set_i)    cnt_d = cnt_val_i;
    else if (ovf_evt) cnt_d = arl_i ? load_i : '0;
    else              cnt_d = cnt_q + CNT_W'(1);
  end

  always_comb begin
    if (!run_i)       pwm_d = 1'b0;
    else if (ovf_evt) pwm_d = 1'b1;
    else if (cmp_evt) pwm_d = 1'b0;
    else              pwm_d = pwm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else pwm_q <= pwm_d;
  end

  assign cnt_o     = cnt_q;
  assign ovf_evt_o = ovf_evt;
  assign cmp_evt_o = cmp_evt;
  assign pwm_o     = pwm_q;
endmodule

// File: rtl/wtmr_ovf_mask.sv
module wtmr_ovf_mask #(
  parameter int unsigned WRAP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap_wr_i,
  input  logic [WRAP_W-1:0] wrap_i,
  input  logic              ovf_evt_i,
  output logic              fire_o
);
  logic [WRAP_W-1:0] seen_q, seen_d;
  logic [WRAP_W:0]   eff_wrap;
  logic [WRAP_W:0]   seen_inc;
  logic              fire;
  logic              seen_en;

  assign eff_wrap = (wrap_i == '0) ? (WRAP_W+1)'(1) : {1'b0, wrap_i};
  assign seen_inc = {1'b0, seen_q} + (WRAP_W+1)'(1);
  assign fire     = ovf_evt_i && !wrap_wr_i && (seen_inc >= eff_wrap);
  assign seen_en  = wrap_wr_i || ovf_evt_i;

  always_comb begin
    if (wrap_wr_i || fire) seen_d = '0;
    else                   seen_d = seen_inc[WRAP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else if (seen_en) seen_q <= seen_d;
  end

  assign fire_o = fire;
endmodule

// File: rtl/wrap_timer.sv
module wrap_timer #(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned WRAP_W   = 16,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned POST_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic              bus_ready,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq_cmp,
  output logic              irq_ovf,
  output logic              pwm_out
);
  import wtmr_pkg::*;

  logic wr_hit;
  logic wr_istat, wr_ien, wr_cmp, wr_wrap;
  logic [NSLOT-1:0]            slot_wr, slot_pend, slot_apply;
  logic [NSLOT-1:0][CNT_W-1:0] slot_data;
  logic [NSLOT-1:0][CNT_W-1:0] slot_wdata;

  ctrl_t             ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  load_q, cmp_q;
  logic [WRAP_W-1:0] wrap_q;
  logic [1:0]        istat_q, istat_d, ien_q;
  logic              run_w, arl_w, cmpen_w;
  logic [CNT_W-1:0]  cnt_w;
  logic              ovf_evt, cmp_evt, ovf_fire;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign wr_hit    = bus_valid && bus_write;
  assign bus_ready = 1'b1;
  assign wr_istat  = wr_hit && hit(bus_addr, OFS_ISTAT);
  assign wr_ien    = wr_hit && hit(bus_addr, OFS_IEN);
  assign wr_cmp    = wr_hit && hit(bus_addr, OFS_CMP);
  assign wr_wrap   = wr_hit && hit(bus_addr, OFS_WRAP);

  assign slot_wr[SLOT_CTRL] = wr_hit && hit(bus_addr, OFS_CTRL);
  assign slot_wr[SLOT_CNT]  = wr_hit && hit(bus_addr, OFS_CNT);
  assign slot_wr[SLOT_LOAD] = wr_hit && hit(bus_addr, OFS_LOAD);

  assign slot_wdata[SLOT_CTRL] = {{(CNT_W-3){1'b0}}, bus_wdata[CTRL_CMP_B],
                                  bus_wdata[CTRL_ARL_B], bus_wdata[CTRL_RUN_B]};
  assign slot_wdata[SLOT_CNT]  = bus_wdata;
  assign slot_wdata[SLOT_LOAD] = bus_wdata;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    wtmr_post_slot #(.DW(CNT_W), .LAT(POST_LAT)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (slot_wr[i]),
      .wdata_i (slot_wdata[i]),
      .pend_o  (slot_pend[i]),
      .apply_o (slot_apply[i]),
      .data_o  (slot_data[i])
    );
  end

  assign ctrl_d = ctrl_t'(slot_data[SLOT_CTRL][2:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (slot_apply[SLOT_CTRL]) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_q <= '0;
    else if (slot_apply[SLOT_LOAD]) load_q <= slot_data[SLOT_LOAD];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= '0;
    else if (wr_cmp) cmp_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wrap_q <= '0;
    else if (wr_wrap) wrap_q <= bus_wdata[WRAP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ien_q <= '0;
    else if (wr_ien) ien_q <= bus_wdata[1:0];
  end

  assign run_w   = ctrl_q.run;
  assign arl_w   = ctrl_q.arl;
  assign cmpen_w = ctrl_q.cmp_en;

  wtmr_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run_w),
    .arl_i     (arl_w),
    .cmp_en_i  (cmpen_w),
    .load_i    (load_q),
    .cmp_i     (cmp_q),
    .cnt_set_i (slot_apply[SLOT_CNT]),
    .cnt_val_i (slot_data[SLOT_CNT]),
    .cnt_o     (cnt_w),
    .ovf_evt_o (ovf_evt),
    .cmp_evt_o (cmp_evt),
    .pwm_o     (pwm_out)
  );

  wtmr_ovf_mask #(.WRAP_W(WRAP_W)) u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrap_wr_i (wr_wrap),
    .wrap_i    (wrap_q),
    .ovf_evt_i (ovf_evt),
    .fire_o    (ovf_fire)
  );

  always_comb begin
    istat_d = istat_q;
    if (wr_istat) istat_d = istat_q & ~bus_wdata[1:0];
    if (cmp_evt)  istat_d[0] = 1'b1;
    if (ovf_fire) istat_d[1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) istat_q <= '0;
    else istat_q <= istat_d;
  end

  assign irq_cmp = istat_q[0] && ien_q[0];
  assign irq_ovf = istat_q[1] && ien_q[1];

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      if (hit(bus_addr, OFS_ISTAT)) bus_rdata = {{(CNT_W-2){1'b0}}, istat_q};
      if (hit(bus_addr, OFS_IEN))   bus_rdata = {{(CNT_W-2){1'b0}}, ien_q};
      if (hit(bus_addr, OFS_CTRL))  bus_rdata = {{(CNT_W-7){1'b0}}, cmpen_w, 4'b0, arl_w, run_w};
      if (hit(bus_addr, OFS_CNT))   bus_rdata = cnt_w;
      if (hit(bus_addr, OFS_LOAD))  bus_rdata = load_q;
      if (hit(bus_addr, OFS_POST))  bus_rdata = {{(CNT_W-NSLOT){1'b0}}, slot_pend};
      if (hit(bus_addr, OFS_CMP))   bus_rdata = cmp_q;
      if (hit(bus_addr, OFS_WRAP))  bus_rdata = {{(CNT_W-WRAP_W){1'b0}}, wrap_q};
    end
  end
endmodule

// File: rtl/wtmr_chk.sv
module wtmr_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             arl,
  input logic             cmp_en,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] load,
  input logic [CNT_W-1:0] cmp,
  input logic             cnt_set,
  input logic             ctrl_wr,
  input logic             ctrl_pend,
  input logic             ctrl_run_stage,
  input logic             istat_wr,
  input logic [1:0]       wdata_lo,
  input logic [1:0]       istat,
  input logic             ovf_fire,
  input logic             pwm
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != CMAX && !cnt_set) |=> (cnt == $past(cnt) + CNT_W'(1)));

  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && arl && cnt == CMAX && !cnt_set) |=> (cnt == $past(load)));

  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !arl && cnt == CMAX && !cnt_set) |=> (cnt == '0));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_set) |=> $stable(cnt));

  p_post_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> ctrl_pend);

  p_post_apply_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_pend) |-> (run == $past(ctrl_run_stage)));

  p_cmp_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(istat[0]) |-> $past(run && cmp_en && cnt == cmp && !cnt_set));

  p_fire_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_fire |-> (run && cnt == CMAX));

  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (istat_wr && wdata_lo[1] && !ovf_fire) |=> !istat[1]);

  p_pwm_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !pwm);
endmodule

bind wrap_timer wtmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .run            (run_w),
  .arl            (arl_w),
  .cmp_en         (cmpen_w),
  .cnt            (cnt_w),
  .load           (load_q),
  .cmp            (cmp_q),
  .cnt_set        (slot_apply[1]),
  .ctrl_wr        (slot_wr[0]),
  .ctrl_pend      (slot_pend[0]),
  .ctrl_run_stage (slot_data[0][0]),
  .istat_wr       (wr_istat),
  .wdata_lo       (bus_wdata[1:0]),
  .istat          (istat_q),
  .ovf_fire       (ovf_fire),
  .pwm            (pwm_out)
);

// File: tb/wrap_timer_tb_top.sv
module wrap_timer_tb_top;
  logic        clk, rst_n;
  logic        bus_valid, bus_write;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_ready, irq_cmp, irq_ovf, pwm_out;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  localparam logic [7:0] A_ISTAT = 8'h28, A_IEN = 8'h2C, A_CTRL = 8'h38,
    A_CNT = 8'h3C, A_LOAD = 8'h40, A_POST = 8'h48, A_CMP = 8'h4C, A_WRAP = 8'h6C;

  wrap_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .irq_cmp(irq_cmp), .irq_ovf(irq_ovf), .pwm_out(pwm_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int exp_interval(input int p, input int n);
    return p * ((n == 0) ? 1 : n);
  endfunction

  function automatic int exp_high(input int h, input int periods);
    return h * periods;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #2;
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int t1, t2, hi, guard;
    void'($urandom(32'd1234));
    bus_valid = 0; bus_write = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 0;
    idle(3);
    rst_n = 1;
    idle(1);

    // R1 reset state
    rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
    rd(A_CNT, v);   chk("R1 counter", v, 0);
    rd(A_POST, v);  chk("R1 pending", v, 0);
    rd(A_ISTAT, v); chk("R1 status", v, 0);
    chk("R1 outputs", {29'b0, irq_cmp, irq_ovf, pwm_out}, 0);

    // R4 posted counter write
    wr(A_CNT, 32'h1234);
    rd(A_POST, v); chk("R4 cnt pend c1", v, 2);
    rd(A_CNT, v);  chk("R4 cnt not yet", v, 0);
    idle(1);
    rd(A_POST, v); chk("R4 cnt pend c2", v, 2);
    idle(1);
    rd(A_POST, v); chk("R4 cnt pend clear", v, 0);
    rd(A_CNT, v);  chk("R4 cnt applied", v, 32'h1234);
    wr(A_LOAD, 32'h100);
    rd(A_POST, v); chk("R4 load pend", v, 4);
    idle(2);
    rd(A_LOAD, v); chk("R4 load applied", v, 32'h100);
    wr(A_CTRL, 32'h2);
    rd(A_POST, v); chk("R4 ctrl pend", v, 1);
    idle(3);

    // R9 hold while stopped
    rd(A_CNT, v); chk("R9 hold", v, 32'h1234);

    // R2 counting
    wr(A_CTRL, 32'h1);
    idle(3);
    rd(A_CNT, v); idle(1); rd(A_CNT, v2);
    chk("R2 step", v2, v + 1);

    // R3 rollover without auto-reload
    wr(A_CTRL, 32'h0); idle(3);
    wr(A_CNT, 32'hFFFF_FFFE); idle(3);
    wr(A_CTRL, 32'h1);
    idle(2); rd(A_CNT, v); chk("R3 at start", v, 32'hFFFF_FFFE);
    idle(1); rd(A_CNT, v); chk("R3 at max", v, 32'hFFFF_FFFF);
    idle(1); rd(A_CNT, v); chk("R3 wrap zero", v, 0);

    // R3 rollover with auto-reload
    wr(A_CTRL, 32'h0); idle(3);
    wr(A_CNT, 32'hFFFF_FFFE); idle(3);
    wr(A_CTRL, 32'h3);
    idle(4); rd(A_CNT, v); chk("R3 reload", v, 32'h100);

    // R5 compare flag and R7 masking / clear
    wr(A_CTRL, 32'h0); idle(3);
    wr(A_IEN, 32'h1);
    wr(A_CMP, 32'h50);
    wr(A_CNT, 32'h4E); idle(3);
    wr(A_ISTAT, 32'h3);
    wr(A_CTRL, 32'h41);
    idle(4); chk("R5 before match", {31'b0, irq_cmp}, 0);
    idle(1); chk("R5 match irq", {31'b0, irq_cmp}, 1);
    wr(A_IEN, 32'h0);
    chk("R7 masked irq", {31'b0, irq_cmp}, 0);
    rd(A_ISTAT, v); chk("R7 flag kept", v, 1);
    wr(A_ISTAT, 32'h1);
    rd(A_ISTAT, v); chk("R7 w1c", v, 0);

    // R6 wrap write restarts rollover count (period 5, N=3)
    wr(A_CTRL, 32'h2); idle(3);
    wr(A_LOAD, 32'hFFFF_FFFB);
    wr(A_CNT, 32'hFFFF_FFFF);
    wr(A_WRAP, 32'h3); idle(3);
    wr(A_CTRL, 32'h3);
    idle(2);
    wr(A_CTRL, 32'h2); idle(4);
    wr(A_WRAP, 32'h3);
    wr(A_IEN, 32'h2);
    wr(A_ISTAT, 32'h3);
    wr(A_CNT, 32'hFFFF_FFFF); idle(3);
    wr(A_CTRL, 32'h3);
    idle(2 + 1 + 5); chk("R6 no flag after 2nd", {31'b0, irq_ovf}, 0);
    idle(5 - 1);     chk("R6 no flag before 3rd", {31'b0, irq_ovf}, 0);
    idle(1);         chk("R6 flag on 3rd", {31'b0, irq_ovf}, 1);

    // R6 / R8 random trials
    for (int t = 0; t < 8; t++) begin
      int p, n, h;
      logic [31:0] ld, cm;
      p = 3 + int'($urandom % 8);
      n = int'($urandom % 5);
      h = 1 + int'($urandom % (p - 1));
      ld = 32'hFFFF_FFFF - 32'(p - 1);
      cm = ld + 32'(h - 1);
      wr(A_CTRL, 32'h0); idle(3);
      wr(A_LOAD, ld);
      wr(A_CNT, ld);
      wr(A_CMP, cm);
      wr(A_WRAP, 32'(n));
      wr(A_IEN, 32'h2);
      wr(A_ISTAT, 32'h3); idle(3);
      wr(A_CTRL, 32'h43); idle(3);
      guard = 0;
      while (!irq_ovf && guard < 200) begin idle(1); guard++; end
      t1 = cyc;
      wr(A_ISTAT, 32'h2);
      guard = 0;
      while (!irq_ovf && guard < 200) begin idle(1); guard++; end
      t2 = cyc;
      chk("R6 interval", 32'(t2 - t1), 32'(exp_interval(p, n)));
      hi = 0;
      for (int k = 0; k < 2 * p; k++) begin
        idle(1);
        if (pwm_out) hi++;
      end
      chk("R8 high cycles", 32'(hi), 32'(exp_high(h, 2)));
    end

    wr(A_CTRL, 32'h0); idle(3);
    chk("R8 low when stopped", {31'b0, pwm_out}, 0);

    summary();
    $finish;
  end
endmodule